// File: doc/BRIEF.md
# GPIO port bank with change interrupt

This block holds the per-pin state of a bank of general-purpose I/O pins, grouped into byte-wide ports (two ports of eight pins by default). Each pin has three control bits and one input bit. The direction bit selects input or output. The drive-level bit sets the level driven while the pin is an output. The invert bit flips the sense of the value seen on the input side. The input bit is latched from the pin. A bus interface in front of the block decodes register accesses into per-port write strobes and per-port read strobes. It shares one write-data byte across all ports.

Pin levels pass through a two-flop synchroniser before they are used. XOR with the invert bits then gives the live input value. A read strobe for a port copies that port's live value into its latched input byte, which the bus interface returns as read data. Whenever any live input bit differs from its latched copy, the block asks for the shared interrupt line to be pulled low. The request goes away when the port is read or when the pins return to their latched value. The interrupt line is open drain and is never driven high.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` all 0), every drive-level bit is 1 (`pin_o` all 1), every invert bit is 0, the latched input bytes are 0, and `int_drive_o` is 0.
- R2: A cycle with `wr_cfg_i[p]` high loads `wr_data_i` into the direction bits of port p (pins p*8 to p*8+7). From the next cycle, a pin whose direction bit is 1 has `pin_oe_o` 0 (input, high impedance), and a pin whose bit is 0 has `pin_oe_o` 1.
- R3: A cycle with `wr_out_i[p]` high loads `wr_data_i` into the drive-level bits of port p, which appear on the matching bits of `pin_o` from the next cycle, whatever the direction bits.
- R4: A cycle with `wr_pol_i[p]` high loads `wr_data_i` into the invert bits of port p. A pin whose invert bit is 1 contributes the complement of its synchronised level to the live input value.
- R5: A level change on `pin_i` reaches the live input value after exactly two rising clock edges.
- R6: A cycle with `rd_i[p]` high copies the live input byte of port p into `in_q_o` bits p*8 to p*8+7 at that edge. Without a read strobe, a port's latched byte does not change.
- R7: The latched input follows the pin level for pins configured as outputs as well as for inputs.
- R8: `int_drive_o` is 1 exactly when at least one live input bit differs from its latched bit. It returns to 0 without any read once the pins come back to the latched values.
- R9: A read strobe on a port removes that port's mismatch, so if no other port mismatches, `int_drive_o` is 0 in the following cycle.
- R10: Write strobes for one port leave the direction, drive-level and invert bits of every other port unchanged.
- R11: Changing an invert bit while its pin is steady changes the live value and so raises the interrupt until the port is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPORTS*PORT_W | Pin levels from the pads |
| pin_oe_o | output | NPORTS*PORT_W | Per-pin driver enable, 1 drives the pin |
| pin_o | output | NPORTS*PORT_W | Per-pin drive level |
| wr_cfg_i | input | NPORTS | Per-port direction write strobe |
| wr_out_i | input | NPORTS | Per-port drive-level write strobe |
| wr_pol_i | input | NPORTS | Per-port invert write strobe |
| wr_data_i | input | PORT_W | Shared write data byte |
| rd_i | input | NPORTS | Per-port input read strobe (latches the input byte) |
| in_q_o | output | NPORTS*PORT_W | Latched, polarity-adjusted input bytes |
| int_drive_o | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
The bench uses the default two ports of eight pins. With two ports it can check that strobes to one port leave the other port alone, and that reading one port does not clear a mismatch pending on the other. Directed steps cover the two-edge synchroniser latency, an interrupt raised only by an invert change, capture from pins configured as outputs, and release of the interrupt when the pins return to the latched value. Seeded random strobes and pin changes then run against a cycle model written in the bench.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPORTS = 2,
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*PORT_W-1:0] pin_i,
  output logic [NPORTS*PORT_W-1:0] pin_oe_o,
  output logic [NPORTS*PORT_W-1:0] pin_o,
  input  logic [NPORTS-1:0]        wr_cfg_i,
  input  logic [NPORTS-1:0]        wr_out_i,
  input  logic [NPORTS-1:0]        wr_pol_i,
  input  logic [PORT_W-1:0]        wr_data_i,
  input  logic [NPORTS-1:0]        rd_i,
  output logic [NPORTS*PORT_W-1:0] in_q_o,
  output logic                     int_drive_o
);
  localparam int N = NPORTS * PORT_W;

  logic [N-1:0] sync_q [SYNC_STAGES];
  logic [N-1:0] dir_q, lvl_q, inv_q, snap_q, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign live = sync_q[SYNC_STAGES-1] ^ inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      lvl_q  <= '1;
      inv_q  <= '0;
      snap_q <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (wr_cfg_i[p]) dir_q[p*PORT_W +: PORT_W] <= wr_data_i;
        if (wr_out_i[p]) lvl_q[p*PORT_W +: PORT_W] <= wr_data_i;
        if (wr_pol_i[p]) inv_q[p*PORT_W +: PORT_W] <= wr_data_i;
        if (rd_i[p])     snap_q[p*PORT_W +: PORT_W] <= live[p*PORT_W +: PORT_W];
      end
    end
  end

  assign pin_oe_o    = ~dir_q;
  assign pin_o       = lvl_q;
  assign in_q_o      = snap_q;
  assign int_drive_o = |(live ^ snap_q);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg_i[p] |=> pin_oe_o[p*PORT_W +: PORT_W] == ~$past(wr_data_i));
    p_lvl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_out_i[p] |=> pin_o[p*PORT_W +: PORT_W] == $past(wr_data_i));
    p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cfg_i[p] |=> $stable(pin_oe_o[p*PORT_W +: PORT_W]));
    p_lvl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out_i[p] |=> $stable(pin_o[p*PORT_W +: PORT_W]));
    p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i[p] |=> $stable(in_q_o[p*PORT_W +: PORT_W]));
    p_snap_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i[p] |=> in_q_o[p*PORT_W +: PORT_W] == $past(live[p*PORT_W +: PORT_W]));
  end
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int NP = 2, W = 8, N = NP * W;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_oe_o, pin_o, in_q_o;
  logic [NP-1:0] wr_cfg_i = '0, wr_out_i = '0, wr_pol_i = '0, rd_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic int_drive_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_dir = '1, m_lvl = '1, m_inv = '0, m_snap = '0, m_s1 = '0, m_s2 = '0;

  always #2 clk = ~clk;

  gpio_bank #(.NPORTS(NP), .PORT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_oe_o(pin_oe_o), .pin_o(pin_o),
    .wr_cfg_i(wr_cfg_i), .wr_out_i(wr_out_i), .wr_pol_i(wr_pol_i),
    .wr_data_i(wr_data_i), .rd_i(rd_i), .in_q_o(in_q_o), .int_drive_o(int_drive_o));

  function automatic logic [N-1:0] put(logic [N-1:0] v, int p, logic [W-1:0] d);
    logic [N-1:0] r = v;
    r[p*W +: W] = d;
    return r;
  endfunction

  function automatic logic exp_int();
    return ((m_s2 ^ m_inv) != m_snap);
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    for (int p = 0; p < NP; p++)
      if (rd_i[p]) m_snap[p*W +: W] = m_s2[p*W +: W] ^ m_inv[p*W +: W];
    m_s2 = m_s1;
    m_s1 = pin_i;
    for (int p = 0; p < NP; p++) begin
      if (wr_cfg_i[p]) m_dir = put(m_dir, p, wr_data_i);
      if (wr_out_i[p]) m_lvl = put(m_lvl, p, wr_data_i);
      if (wr_pol_i[p]) m_inv = put(m_inv, p, wr_data_i);
    end
    @(negedge clk);
    check("R2 model", pin_oe_o, ~m_dir);
    check("R3 model", pin_o, m_lvl);
    check("R6 model", in_q_o, m_snap);
    check("R8 model", {15'd0, int_drive_o}, {15'd0, exp_int()});
    wr_cfg_i = '0; wr_out_i = '0; wr_pol_i = '0; rd_i = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 oe", pin_oe_o, 16'h0000);
    check("R1 level", pin_o, 16'hFFFF);
    check("R1 latched", in_q_o, 16'h0000);
    check("R1 int", {15'd0, int_drive_o}, 16'd0);
    rst_n = 1;
    tick();

    // R5 two-edge latency
    pin_i = 16'h00A5;
    tick();
    check("R5 one edge", {15'd0, int_drive_o}, 16'd0);
    tick();
    check("R5 two edges", {15'd0, int_drive_o}, 16'd1);

    // R6 / R9 read clears
    rd_i = 2'b01; tick();
    check("R6 capture", in_q_o, 16'h00A5);
    check("R9 cleared", {15'd0, int_drive_o}, 16'd0);

    // R11 invert raises interrupt, R4 inverted capture
    wr_pol_i = 2'b01; wr_data_i = 8'hFF; tick();
    check("R11 invert int", {15'd0, int_drive_o}, 16'd1);
    rd_i = 2'b01; tick();
    check("R4 inverted", in_q_o, 16'h005A);
    check("R11 cleared", {15'd0, int_drive_o}, 16'd0);

    // R2 / R3 / R10 port 1 only
    wr_cfg_i = 2'b10; wr_data_i = 8'h00; tick();
    check("R2 dir", pin_oe_o, 16'hFF00);
    wr_out_i = 2'b10; wr_data_i = 8'h3C; tick();
    check("R3 level", pin_o, 16'h3CFF);
    check("R10 other port", pin_oe_o, 16'hFF00);

    // R7 capture from output pins
    pin_i = 16'h3CA5; tick(); tick();
    check("R7 int", {15'd0, int_drive_o}, 16'd1);
    rd_i = 2'b10; tick();
    check("R7 capture", in_q_o, 16'h3C5A);

    // R8 release on return; R9 per port
    pin_i = 16'h00A5; tick(); tick();
    check("R8 raised", {15'd0, int_drive_o}, 16'd1);
    pin_i = 16'h3CA5; tick(); tick();
    check("R8 released", {15'd0, int_drive_o}, 16'd0);
    pin_i = 16'h3DA4; tick(); tick();
    rd_i = 2'b10; tick();
    check("R9 other port pending", {15'd0, int_drive_o}, 16'd1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) pin_i = N'($urandom);
      wr_data_i = W'($urandom);
      wr_cfg_i = (($urandom % 8) == 0) ? NP'($urandom) : '0;
      wr_out_i = (($urandom % 8) == 0) ? NP'($urandom) : '0;
      wr_pol_i = (($urandom % 16) == 0) ? NP'($urandom) : '0;
      rd_i     = (($urandom % 5) == 0) ? NP'($urandom) : '0;
      tick();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule